// File: doc/BRIEF.md
# Match-Output Timer

This block is a free-running up-counter with four compare channels. The counter advances on a prescaled internal clock, or on edges of an external count input that it first synchronizes. Each compare channel watches the count. When the count reaches the channel's value, the channel applies a programmable action to its own output pin. It can also raise a sticky interrupt flag, clear the counter or halt it.

The first two channels also send a one-cycle request pulse to a DMA engine. This lets count events pace memory transfers without software involvement.

Software configures the block through a flat word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `match_timer`

## Requirements
- R1: After reset the control word, counter, prescale counter and interrupt flags read 0. All match outputs, DMA request lines and the interrupt line are low.
- R2: In internal-clock mode, with the run bit set and hold clear, the prescale counter counts 0 up to the prescale value. On the clock edge where it equals that value, it returns to 0 and the counter increments by one. The counter wraps from all ones to zero.
- R3: Each channel n has a 2-bit action field at bits [2n+1:2n] of the action register: 00 leaves the output unchanged, 01 drives it low, 10 drives it high, 11 toggles it. The output takes its new value on the clock edge that ends the match cycle.
- R4: A match event for a channel occurs in a cycle where the block is running, the counter equals the channel's value, and it did not equal that value in the previous cycle. A value held for several cycles yields exactly one event.
- R5: The channel-n configuration bit 3n enables the interrupt. An event on an enabled channel sets flag n on the following edge. The flags stay set until a 1 is written to their bit of the flag register; written 0 bits leave them alone. The interrupt line is the OR of all flags.
- R6: Configuration bit 3n+1 makes an event on channel n clear both the counter and the prescale counter on the next edge.
- R7: Configuration bit 3n+2 makes an event on channel n clear the run bit on the next edge. The counter keeps the matched value and does not increment that edge.
- R8: When several channels match in the same cycle, every enabled action of every matching channel is applied on the same edge.
- R9: Channels 0 and 1 drive DMA request bits 0 and 1. Each request is high for exactly one cycle, on the cycle after its channel's event.
- R10: With source field 01, 10 or 11, the prescaler advances only on rising, falling or both edges of the external input. The input passes through a two-flop synchronizer first, so the counter reflects an input change on the third rising clock edge after it.
- R11: While the hold bit is set, the counter and prescale counter stay zero and no events occur.
- R12: Register map, word addresses:
  - 0: control word — bit 0 run, bit 1 hold, bits [3:2] source (00 internal).
  - 1: prescale value.
  - 2: counter (writable).
  - 3: prescale counter.
  - 4: channel configuration.
  - 5: actions.
  - 6: flags.
  - 7: output pin state (writable).
  - 8 + n: match value n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| extCount | input | 1 | External count input, asynchronous |
| matchOut | output | 4 | Per-channel match output pins |
| dmaReq | output | 2 | Single-cycle DMA request pulses, channels 0 and 1 |
| irq | output | 1 | OR of the sticky interrupt flags |

## Verification
The assertions take for granted that software changes the counter only through the counter register or the hold bit. They also assume that a match value is not rewritten in a way that makes the counter equal to it on two consecutive running cycles, since the single-cycle pulse check depends on that.

The stimulus configures channels only while the hold bit is set. It starts the counter from zero with a single control write, so every match arrives by counting. It toggles the external input on falling clock edges and holds each level for several cycles, so the synchronizer always sees clean levels.

// File: rtl/mt_pkg.sv
package mt_pkg;
  parameter int CNT_W   = 32;
  parameter int NUM_CH  = 4;
  parameter int NUM_DMA = 2;
  parameter int ADDR_W  = 4;

  localparam int CFG_W = 3 * NUM_CH;
  localparam int ACT_W = 2 * NUM_CH;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRE    = 'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT    = 'd2;
  localparam logic [ADDR_W-1:0] ADDR_PCNT   = 'd3;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 'd4;
  localparam logic [ADDR_W-1:0] ADDR_ACT    = 'd5;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 'd6;
  localparam logic [ADDR_W-1:0] ADDR_OUT    = 'd7;
  localparam int                ADDR_MATCH0 = 8;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } outAct_e;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'b00,
    SRC_RISE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_BOTH = 2'b11
  } cntSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;      // advance prescaler this cycle
    logic              armed;     // running, events allowed
    logic              holdZero;  // force counters to zero
    logic              cntLoad;   // software load of counter
    logic              outLoad;   // software load of output pins
    logic [NUM_CH-1:0] rstMask;   // channels that clear counter on event
    logic [CNT_W-1:0]  loadVal;
  } dpCmd_t;
endpackage

// File: rtl/mt_edge_sync.sv
module mt_edge_sync
  import mt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    din,
  input  cntSrc_e mode,
  output logic    pulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], din};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign fall = ~syncQ[SYNC_STAGES-1] & prevQ;

  always_comb begin
    case (mode)
      SRC_RISE: pulse = rise;
      SRC_FALL: pulse = fall;
      SRC_BOTH: pulse = rise | fall;
      default:  pulse = 1'b0;
    endcase
  end

  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (mode == SRC_CLK) |-> !pulse); // R10
endmodule

// File: rtl/mt_datapath.sv
module mt_datapath
  import mt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCmd_t                        cmd,
  input  logic [CNT_W-1:0]              prescale,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  matchVal,
  input  logic [NUM_CH-1:0][1:0]        actions,
  output logic [CNT_W-1:0]              count,
  output logic [CNT_W-1:0]              pcount,
  output logic [NUM_CH-1:0]             matchEvt,
  output logic [NUM_CH-1:0]             matchOut,
  output logic [NUM_DMA-1:0]            dmaReq
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] prevHit;
  logic [NUM_CH-1:0] outNext;
  logic              rstHit;

  for (genvar c = 0; c < NUM_CH; c++) begin : gHit
    assign hit[c] = (count == matchVal[c]);
  end

  assign matchEvt = hit & ~prevHit & {NUM_CH{cmd.armed}};
  assign rstHit   = |(matchEvt & cmd.rstMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevHit <= '1;
    else       prevHit <= hit;
  end

  // counter and prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      pcount <= '0;
    end else if (cmd.holdZero) begin
      count  <= '0;
      pcount <= '0;
    end else if (cmd.cntLoad) begin
      count  <= cmd.loadVal;
    end else if (rstHit) begin
      count  <= '0;
      pcount <= '0;
    end else if (cmd.tick) begin
      if (pcount >= prescale) begin
        pcount <= '0;
        count  <= count + ONE;
      end else begin
        pcount <= pcount + ONE;
      end
    end
  end

  // output pin actions
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      outNext[c] = matchOut[c];
      if (cmd.outLoad) begin
        outNext[c] = cmd.loadVal[c];
      end else if (matchEvt[c]) begin
        case (outAct_e'(actions[c]))
          ACT_LOW:    outNext[c] = 1'b0;
          ACT_HIGH:   outNext[c] = 1'b1;
          ACT_TOGGLE: outNext[c] = ~matchOut[c];
          default:    outNext[c] = matchOut[c];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchOut <= '0;
    else       matchOut <= outNext;
  end

  // DMA pacing pulses
  for (genvar d = 0; d < NUM_DMA; d++) begin : gDma
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dmaReq[d] <= 1'b0;
      else       dmaReq[d] <= matchEvt[d];
    end
    AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[d] |=> !dmaReq[d]); // R9
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.holdZero |=> (count == '0 && pcount == '0)); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.cntLoad |=> (count == $past(count) || count == $past(count) + ONE || count == '0)); // R2
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt == '0 && !cmd.outLoad) |=> $stable(matchOut)); // R3
  AST_EVT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt != '0) |=> ((matchEvt & $past(matchEvt)) == '0)); // R4
endmodule

// File: rtl/mt_control.sv
module mt_control
  import mt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [CNT_W-1:0]              regWdata,
  output logic [CNT_W-1:0]              regRdata,
  input  logic                          extPulse,
  input  logic [NUM_CH-1:0]             matchEvt,
  input  logic [CNT_W-1:0]              count,
  input  logic [CNT_W-1:0]              pcount,
  input  logic [NUM_CH-1:0]             matchOut,
  output dpCmd_t                        cmd,
  output cntSrc_e                       srcMode,
  output logic [CNT_W-1:0]              prescale,
  output logic [NUM_CH-1:0][CNT_W-1:0]  matchVal,
  output logic [NUM_CH-1:0][1:0]        actions,
  output logic                          irq
);
  logic              runQ;
  logic              holdQ;
  logic [CFG_W-1:0]  cfgQ;
  logic [NUM_CH-1:0] flagsQ;
  logic [NUM_CH-1:0] irqEn;
  logic [NUM_CH-1:0] rstEn;
  logic [NUM_CH-1:0] stopEn;
  logic [NUM_CH-1:0] flagClr;
  logic              stopNow;
  logic              ctrlWr;
  logic              srcTick;

  for (genvar c = 0; c < NUM_CH; c++) begin : gCfg
    assign irqEn[c]  = cfgQ[3*c];
    assign rstEn[c]  = cfgQ[3*c+1];
    assign stopEn[c] = cfgQ[3*c+2];
  end

  assign ctrlWr  = regWe && (regAddr == ADDR_CTRL);
  assign stopNow = |(matchEvt & stopEn);
  assign srcTick = (srcMode == SRC_CLK) ? 1'b1 : extPulse;
  assign flagClr = (regWe && regAddr == ADDR_FLAGS) ? regWdata[NUM_CH-1:0] : '0;

  always_comb begin
    cmd          = '0;
    cmd.tick     = runQ & ~holdQ & ~stopNow & srcTick;
    cmd.armed    = runQ & ~holdQ;
    cmd.holdZero = holdQ;
    cmd.cntLoad  = regWe && (regAddr == ADDR_CNT);
    cmd.outLoad  = regWe && (regAddr == ADDR_OUT);
    cmd.rstMask  = rstEn;
    cmd.loadVal  = regWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      holdQ    <= 1'b0;
      srcMode  <= SRC_CLK;
      prescale <= '0;
      cfgQ     <= '0;
      actions  <= '0;
      matchVal <= '0;
      flagsQ   <= '0;
    end else begin
      if (ctrlWr) begin
        runQ    <= regWdata[0];
        holdQ   <= regWdata[1];
        srcMode <= cntSrc_e'(regWdata[3:2]);
      end else if (stopNow) begin
        runQ <= 1'b0;
      end
      if (regWe && regAddr == ADDR_PRE) prescale <= regWdata;
      if (regWe && regAddr == ADDR_CFG) cfgQ <= regWdata[CFG_W-1:0];
      if (regWe && regAddr == ADDR_ACT) actions <= regWdata[ACT_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (regWe && regAddr == ADDR_W'(ADDR_MATCH0 + c)) matchVal[c] <= regWdata;
      end
      flagsQ <= (flagsQ & ~flagClr) | (matchEvt & irqEn);
    end
  end

  assign irq = |flagsQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:  regRdata = CNT_W'({srcMode, holdQ, runQ});
      ADDR_PRE:   regRdata = prescale;
      ADDR_CNT:   regRdata = count;
      ADDR_PCNT:  regRdata = pcount;
      ADDR_CFG:   regRdata = CNT_W'(cfgQ);
      ADDR_ACT:   regRdata = CNT_W'(actions);
      ADDR_FLAGS: regRdata = CNT_W'(flagsQ);
      ADDR_OUT:   regRdata = CNT_W'(matchOut);
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (regAddr == ADDR_W'(ADDR_MATCH0 + c)) regRdata = matchVal[c];
        end
      end
    endcase
  end

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (stopNow && !ctrlWr) |=> !runQ); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagsQ & $past(flagsQ & ~flagClr)) == $past(flagsQ & ~flagClr))); // R5
  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ((matchEvt & irqEn) != '0) |=> irq); // R5
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CNT_W-1:0]    regWdata,
  output logic [CNT_W-1:0]    regRdata,
  input  logic                extCount,
  output logic [NUM_CH-1:0]   matchOut,
  output logic [NUM_DMA-1:0]  dmaReq,
  output logic                irq
);
  dpCmd_t                       cmd;
  cntSrc_e                      srcMode;
  logic                         extPulse;
  logic [CNT_W-1:0]             prescale;
  logic [NUM_CH-1:0][CNT_W-1:0] matchVal;
  logic [NUM_CH-1:0][1:0]       actions;
  logic [CNT_W-1:0]             count;
  logic [CNT_W-1:0]             pcount;
  logic [NUM_CH-1:0]            matchEvt;

  mt_edge_sync #(.SYNC_STAGES(2)) uEdge (
    .clk   (clk),
    .rstN  (rstN),
    .din   (extCount),
    .mode  (srcMode),
    .pulse (extPulse)
  );

  mt_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .extPulse (extPulse),
    .matchEvt (matchEvt),
    .count    (count),
    .pcount   (pcount),
    .matchOut (matchOut),
    .cmd      (cmd),
    .srcMode  (srcMode),
    .prescale (prescale),
    .matchVal (matchVal),
    .actions  (actions),
    .irq      (irq)
  );

  mt_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .prescale (prescale),
    .matchVal (matchVal),
    .actions  (actions),
    .count    (count),
    .pcount   (pcount),
    .matchEvt (matchEvt),
    .matchOut (matchOut),
    .dmaReq   (dmaReq)
  );
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
  localparam int KIND_REG = 0;
  localparam int KIND_OUT = 1;
  localparam int KIND_DMA = 2;
  localparam int KIND_IRQ = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        extCount = 1'b0;
  logic [3:0]  matchOut;
  logic [1:0]  dmaReq;
  logic        irq;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;

  match_timer uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extCount(extCount),
    .matchOut(matchOut), .dmaReq(dmaReq), .irq(irq)
  );

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      wait (expQ.size() != 0);
      begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          KIND_REG: act = regRdata;
          KIND_OUT: act = 32'(matchOut);
          KIND_DMA: act = 32'(dmaReq);
          default:  act = 32'(irq);
        endcase
        applied++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: got %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    regAddr = a;
    #2;
    pushExp(KIND_REG, e, tag);
  endtask

  task automatic pulseExt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extCount = 1'b1;
      waitN(3); extCount = 1'b0;
      waitN(3);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd2, 32'h0, "R1 count");
    rd(4'd6, 32'h0, "R1 flags");
    pushExp(KIND_OUT, 32'h0, "R1 matchOut");
    pushExp(KIND_DMA, 32'h0, "R1 dmaReq");
    pushExp(KIND_IRQ, 32'h0, "R1 irq");

    // R2 prescaled counting
    wr(4'd1, 32'd3);
    wr(4'd0, 32'h1);
    waitN(10);
    rd(4'd2, 32'd2, "R2 count after 10 cycles, prescale 3");
    rd(4'd3, 32'd2, "R2 prescale counter");

    // R11 hold
    wr(4'd0, 32'h2);
    waitN(3);
    rd(4'd2, 32'd0, "R11 count held");
    rd(4'd3, 32'd0, "R11 prescale held");

    // R3 / R8 / R9 / R5 actions
    wr(4'd1, 32'd0);
    wr(4'd8, 32'd5);
    wr(4'd9, 32'd7);
    wr(4'd10, 32'd7);
    wr(4'd11, 32'd9);
    wr(4'd5, 32'h1B);
    wr(4'd7, 32'h4);
    wr(4'd4, 32'h200);
    rd(4'd7, 32'h4, "R12 output preset");
    wr(4'd0, 32'h1);
    waitN(5);
    rd(4'd2, 32'd5, "R2 count at match");
    pushExp(KIND_OUT, 32'h4, "R3 before edge");
    pushExp(KIND_DMA, 32'h0, "R9 before edge");
    waitN(1);
    pushExp(KIND_OUT, 32'h5, "R3 toggle");
    pushExp(KIND_DMA, 32'h1, "R9 dma ch0");
    waitN(1);
    pushExp(KIND_DMA, 32'h0, "R9 single cycle");
    waitN(1);
    pushExp(KIND_OUT, 32'h3, "R8 high and low same edge");
    pushExp(KIND_DMA, 32'h2, "R9 dma ch1");
    waitN(2);
    pushExp(KIND_IRQ, 32'h1, "R5 irq");
    pushExp(KIND_OUT, 32'h3, "R3 keep");
    rd(4'd6, 32'h8, "R5 flag set");
    wr(4'd6, 32'h7);
    waitN(2);
    rd(4'd6, 32'h8, "R5 zero bits leave flag");
    wr(4'd6, 32'h8);
    rd(4'd6, 32'h0, "R5 w1c");
    pushExp(KIND_IRQ, 32'h0, "R5 irq cleared");

    // R4 / R9 no re-issue while equal
    wr(4'd0, 32'h2);
    wr(4'd5, 32'h0);
    wr(4'd4, 32'h0);
    wr(4'd1, 32'd3);
    wr(4'd8, 32'd100);
    wr(4'd9, 32'd2);
    wr(4'd10, 32'd100);
    wr(4'd11, 32'd100);
    wr(4'd0, 32'h1);
    waitN(9);
    pushExp(KIND_DMA, 32'h2, "R9 dma on arrival");
    waitN(1);
    pushExp(KIND_DMA, 32'h0, "R4 no repeat");
    rd(4'd2, 32'd2, "R4 still equal");
    waitN(1);
    pushExp(KIND_DMA, 32'h0, "R4 no repeat later");
    waitN(2);
    rd(4'd2, 32'd3, "R2 next step");

    // R6 reset on match
    wr(4'd0, 32'h2);
    wr(4'd1, 32'd0);
    wr(4'd8, 32'd3);
    wr(4'd9, 32'd100);
    wr(4'd4, 32'h2);
    wr(4'd0, 32'h1);
    waitN(6);
    rd(4'd2, 32'd2, "R6 count restarted");

    // R8 reset + stop + two irqs in one cycle
    wr(4'd0, 32'h2);
    wr(4'd8, 32'd4);
    wr(4'd10, 32'd4);
    wr(4'd4, 32'h143);
    wr(4'd0, 32'h1);
    waitN(8);
    rd(4'd2, 32'd0, "R8 reset applied");
    rd(4'd0, 32'd0, "R8 stop applied");
    rd(4'd6, 32'h5, "R8 both flags");
    pushExp(KIND_IRQ, 32'h1, "R8 irq");
    wr(4'd6, 32'hF);

    // R7 stop holds value
    wr(4'd0, 32'h2);
    wr(4'd4, 32'h100);
    wr(4'd0, 32'h1);
    waitN(8);
    rd(4'd2, 32'd4, "R7 count holds match");
    rd(4'd0, 32'd0, "R7 run cleared");

    // R12 counter load
    wr(4'd2, 32'h1234);
    rd(4'd2, 32'h1234, "R12 counter write");
    rd(4'd10, 32'd4, "R12 match readback");

    // R10 external edges
    wr(4'd0, 32'h2);
    wr(4'd4, 32'h0);
    wr(4'd8, 32'd100);
    wr(4'd10, 32'd100);
    wr(4'd0, 32'h5);
    waitN(4);
    rd(4'd2, 32'd0, "R10 no internal counting");
    @(negedge clk); extCount = 1'b1;
    waitN(1);
    rd(4'd2, 32'd0, "R10 latency 1");
    waitN(1);
    rd(4'd2, 32'd0, "R10 latency 2");
    waitN(1);
    rd(4'd2, 32'd1, "R10 latency 3");
    extCount = 1'b0;
    waitN(3);
    pulseExt(2);
    waitN(5);
    rd(4'd2, 32'd3, "R10 rising");
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h9);
    pulseExt(3);
    waitN(5);
    rd(4'd2, 32'd3, "R10 falling");
    wr(4'd0, 32'h2);
    wr(4'd0, 32'hD);
    pulseExt(3);
    waitN(5);
    rd(4'd2, 32'd6, "R10 both");

    wait (expQ.size() == 0);
    #5;
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule